// File: doc/BRIEF.md
# Receive Completion Ring Writer

This block is the hardware half of a receive descriptor ring. Software owns a ring of buffers whose size is a power of two, given as its base-2 logarithm. Software hands buffers to the block by writing a running producer index. For every packet the receive path reports, with a length and two error flags, the block claims the next owned slot. It writes one completion entry into ring memory through a synchronous write port, advances its running completion index and raises a receive interrupt.

Ownership of a completion entry is carried by a valid bit whose written polarity inverts each time the completion index wraps to slot 0. Software therefore never has to clear old entries. It pre-fills the valid bits with 1 and first expects 0. A packet that finds no owned buffer is dropped and counted. While the DMA enable is low, packets are ignored entirely. Moving the payload itself is outside this block.

Top module: `rxcq_ring_writer`

## Requirements
- R1: After reset the completion index, producer index and drop count are 0, no write is issued, and the interrupt pending flag and interrupt output are low.
- R2: An accepted packet produces exactly one memory write in the clock cycle after it is presented. The write address is the completion index modulo 2^ring_log2, and the completion index then rises by one. ring_log2 ranges from 0 to MAX_LOG2.
- R3: The entry layout is as follows: bits [LEN_W-1:0] hold the length, bit LEN_W is the MAC-error flag, bit LEN_W+1 is the truncated flag, and bit LEN_W+2 is the valid bit. A status of zero in bits LEN_W+1:LEN_W marks a good packet.
- R4: The valid bit is 0 for completion indices 0 to 2^ring_log2-1. It inverts every time the completion index crosses a multiple of the ring size, so it equals bit ring_log2 of the completion index being written.
- R5: A write on the producer port loads the running producer index. A packet is accepted only while the completion index differs from the producer index.
- R6: A packet presented while the DMA enable is high and the completion index equals the producer index is dropped. The drop count rises by one, no write is issued and the completion index does not change.
- R7: While the DMA enable is low, a presented packet issues no write and changes neither the completion index nor the drop count.
- R8: The interrupt pending flag sets on every completion write. A pulse on the clear input resets it. When a write and a clear fall in the same cycle, the flag stays set.
- R9: The interrupt output is high exactly when the pending flag is set and the mask input is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_ring_log2 | input | LOG_W | Base-2 logarithm of the ring size |
| dma_en | input | 1 | Gates all completion writes |
| prod_wr | input | 1 | Producer index write strobe |
| prod_wdata | input | IDX_W | New running producer index |
| irq_mask | input | 1 | Masks the receive interrupt when high |
| irq_clear | input | 1 | Clears the pending flag when pulsed |
| pkt_valid | input | 1 | One-cycle packet report |
| pkt_len | input | LEN_W | Packet length |
| pkt_mac_err | input | 1 | MAC error flag |
| pkt_trunc | input | 1 | Truncated flag |
| cq_we | output | 1 | Completion memory write enable |
| cq_addr | output | SLOT_W | Completion slot address |
| cq_wdata | output | LEN_W+3 | Completion entry |
| cons_idx | output | IDX_W | Running completion index |
| drop_cnt | output | CNT_W | Packets dropped for lack of buffers |
| irq_pending | output | 1 | Interrupt pending flag |
| irq | output | 1 | Receive interrupt |

## Verification
Every result is registered once. The write strobe, address, entry, completion index, drop count and pending flag all change on the rising edge that samples the packet or clear pulse, and the interrupt follows that same edge through logic. The bench drives each stimulus for one cycle starting at a falling edge. It samples every output at the next falling edge, half a cycle after the edge that updated it. Register changes and mask changes are therefore read only once they have settled.

// File: rtl/rxcq_pkg.sv
package rxcq_pkg;
  localparam int STAT_MAC_ERR = 0;
  localparam int STAT_TRUNC   = 1;

  typedef enum logic [1:0] {
    ACT_IDLE  = 2'd0,
    ACT_WRITE = 2'd1,
    ACT_DROP  = 2'd2
  } rx_act_e;
endpackage

// File: rtl/rxcq_slot_tracker.sv
module rxcq_slot_tracker #(
  parameter int IDX_W    = 16,
  parameter int MAX_LOG2 = 4,
  parameter int SLOT_W   = 4,
  parameter int LOG_W    = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [LOG_W-1:0]  cfg_log2,
  input  logic              prod_wr,
  input  logic [IDX_W-1:0]  prod_wdata,
  input  logic              advance,
  output logic [IDX_W-1:0]  cons_q,
  output logic [IDX_W-1:0]  prod_q,
  output logic [SLOT_W-1:0] slot,
  output logic              pol_q,
  output logic              has_free
);
  logic [LOG_W-1:0] eff_lg;
  logic [IDX_W-1:0] ring_mask;
  logic [IDX_W-1:0] cons_inc;
  logic [IDX_W-1:0] cons_d;
  logic [IDX_W-1:0] prod_d;
  logic             pol_d;
  logic             wraps;

  always_comb begin
    eff_lg    = (cfg_log2 > LOG_W'(MAX_LOG2)) ? LOG_W'(MAX_LOG2) : cfg_log2;
    ring_mask = (IDX_W'(1) << eff_lg) - IDX_W'(1);
    slot      = SLOT_W'(cons_q & ring_mask);
    has_free  = (cons_q != prod_q);
    cons_inc  = cons_q + IDX_W'(1);
    wraps     = ((cons_inc & ring_mask) == '0);
    cons_d    = advance ? cons_inc : cons_q;
    pol_d     = (advance && wraps) ? ~pol_q : pol_q;
    prod_d    = prod_wr ? prod_wdata : prod_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cons_q <= '0;
      prod_q <= '0;
      pol_q  <= 1'b0;
    end else begin
      if (advance) begin
        cons_q <= cons_d;
        pol_q  <= pol_d;
      end
      if (prod_wr) begin
        prod_q <= prod_d;
      end
    end
  end
endmodule

// File: rtl/rxcq_entry_fmt.sv
module rxcq_entry_fmt
  import rxcq_pkg::*;
#(
  parameter int LEN_W  = 14,
  parameter int SLOT_W = 4,
  parameter int ENT_W  = LEN_W + 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  rx_act_e           act,
  input  logic [SLOT_W-1:0] slot,
  input  logic [LEN_W-1:0]  len,
  input  logic              mac_err,
  input  logic              trunc,
  input  logic              pol,
  output logic              cq_we,
  output logic [SLOT_W-1:0] cq_addr,
  output logic [ENT_W-1:0]  cq_wdata
);
  logic             we_d;
  logic [ENT_W-1:0] ent_d;
  logic [1:0]       status;

  always_comb begin
    status               = '0;
    status[STAT_MAC_ERR] = mac_err;
    status[STAT_TRUNC]   = trunc;
    ent_d                = {pol, status, len};
    we_d                 = (act == ACT_WRITE);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cq_we    <= 1'b0;
      cq_addr  <= '0;
      cq_wdata <= '0;
    end else begin
      cq_we <= we_d;
      if (we_d) begin
        cq_addr  <= slot;
        cq_wdata <= ent_d;
      end
    end
  end
endmodule

// File: rtl/rxcq_event_regs.sv
module rxcq_event_regs
  import rxcq_pkg::*;
#(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  rx_act_e          act,
  input  logic             irq_clear,
  output logic             pend_q,
  output logic [CNT_W-1:0] drop_q
);
  logic             pend_d;
  logic             pend_en;
  logic [CNT_W-1:0] drop_d;
  logic             drop_en;

  always_comb begin
    pend_en = (act == ACT_WRITE) || irq_clear;
    pend_d  = (act == ACT_WRITE);
    drop_en = (act == ACT_DROP);
    drop_d  = drop_q + CNT_W'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pend_q <= 1'b0;
      drop_q <= '0;
    end else begin
      if (pend_en) pend_q <= pend_d;
      if (drop_en) drop_q <= drop_d;
    end
  end
endmodule

// File: rtl/rxcq_ring_writer.sv
module rxcq_ring_writer
  import rxcq_pkg::*;
#(
  parameter int IDX_W    = 16,
  parameter int LEN_W    = 14,
  parameter int MAX_LOG2 = 4,
  parameter int CNT_W    = 16,
  localparam int LOG_W   = $clog2(MAX_LOG2 + 1),
  localparam int SLOT_W  = MAX_LOG2,
  localparam int ENT_W   = LEN_W + 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [LOG_W-1:0]  cfg_ring_log2,
  input  logic              dma_en,
  input  logic              prod_wr,
  input  logic [IDX_W-1:0]  prod_wdata,
  input  logic              irq_mask,
  input  logic              irq_clear,
  input  logic              pkt_valid,
  input  logic [LEN_W-1:0]  pkt_len,
  input  logic              pkt_mac_err,
  input  logic              pkt_trunc,
  output logic              cq_we,
  output logic [SLOT_W-1:0] cq_addr,
  output logic [ENT_W-1:0]  cq_wdata,
  output logic [IDX_W-1:0]  cons_idx,
  output logic [CNT_W-1:0]  drop_cnt,
  output logic              irq_pending,
  output logic              irq
);
  rx_act_e           act;
  logic [IDX_W-1:0]  prod_q;
  logic [SLOT_W-1:0] slot;
  logic              pol_q;
  logic              has_free;

  always_comb begin
    if (pkt_valid && dma_en) act = has_free ? ACT_WRITE : ACT_DROP;
    else                     act = ACT_IDLE;
  end

  rxcq_slot_tracker #(
    .IDX_W(IDX_W), .MAX_LOG2(MAX_LOG2), .SLOT_W(SLOT_W), .LOG_W(LOG_W)
  ) u_track (
    .clk(clk), .rst_n(rst_n), .cfg_log2(cfg_ring_log2),
    .prod_wr(prod_wr), .prod_wdata(prod_wdata),
    .advance(act == ACT_WRITE),
    .cons_q(cons_idx), .prod_q(prod_q), .slot(slot),
    .pol_q(pol_q), .has_free(has_free)
  );

  rxcq_entry_fmt #(
    .LEN_W(LEN_W), .SLOT_W(SLOT_W), .ENT_W(ENT_W)
  ) u_fmt (
    .clk(clk), .rst_n(rst_n), .act(act), .slot(slot),
    .len(pkt_len), .mac_err(pkt_mac_err), .trunc(pkt_trunc), .pol(pol_q),
    .cq_we(cq_we), .cq_addr(cq_addr), .cq_wdata(cq_wdata)
  );

  rxcq_event_regs #(
    .CNT_W(CNT_W)
  ) u_evt (
    .clk(clk), .rst_n(rst_n), .act(act), .irq_clear(irq_clear),
    .pend_q(irq_pending), .drop_q(drop_cnt)
  );

  assign irq = irq_pending & ~irq_mask;
endmodule

// File: rtl/rxcq_ring_writer_chk.sv
module rxcq_ring_writer_chk #(
  parameter int IDX_W    = 16,
  parameter int LEN_W    = 14,
  parameter int MAX_LOG2 = 4,
  parameter int CNT_W    = 16,
  parameter int LOG_W    = 3,
  parameter int SLOT_W   = 4,
  parameter int ENT_W    = 17
) (
  input logic              clk,
  input logic              rst_n,
  input logic [LOG_W-1:0]  cfg_ring_log2,
  input logic              dma_en,
  input logic              pkt_valid,
  input logic              irq_mask,
  input logic              cq_we,
  input logic [SLOT_W-1:0] cq_addr,
  input logic [ENT_W-1:0]  cq_wdata,
  input logic [IDX_W-1:0]  cons_idx,
  input logic [IDX_W-1:0]  prod_q,
  input logic [CNT_W-1:0]  drop_cnt,
  input logic              irq_pending,
  input logic              irq
);
  assert_accept_writes_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (pkt_valid && dma_en && cons_idx != prod_q) |=> cq_we);

  assert_index_step_R2: assert property (@(posedge clk) disable iff (!rst_n)
    cq_we |-> cons_idx == $past(cons_idx) + IDX_W'(1));

  assert_slot_addr_R2: assert property (@(posedge clk) disable iff (!rst_n)
    cq_we |-> IDX_W'(cq_addr) ==
      ($past(cons_idx) & ((IDX_W'(1) << $past(cfg_ring_log2)) - IDX_W'(1))));

  assert_valid_polarity_R4: assert property (@(posedge clk) disable iff (!rst_n)
    cq_we |-> IDX_W'(cq_wdata[LEN_W+2]) ==
      (($past(cons_idx) >> $past(cfg_ring_log2)) & IDX_W'(1)));

  assert_drop_counts_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (pkt_valid && dma_en && cons_idx == prod_q) |=>
      (!cq_we && drop_cnt == $past(drop_cnt) + CNT_W'(1)));

  assert_dma_gate_R7: assert property (@(posedge clk) disable iff (!rst_n)
    !dma_en |=> !cq_we);

  assert_pending_on_write_R8: assert property (@(posedge clk) disable iff (!rst_n)
    cq_we |-> irq_pending);

  assert_mask_blocks_R9: assert property (@(posedge clk) disable iff (!rst_n)
    irq_mask |-> !irq);
endmodule

bind rxcq_ring_writer rxcq_ring_writer_chk #(
  .IDX_W(IDX_W), .LEN_W(LEN_W), .MAX_LOG2(MAX_LOG2), .CNT_W(CNT_W),
  .LOG_W(LOG_W), .SLOT_W(SLOT_W), .ENT_W(ENT_W)
) u_chk (.*);

// File: tb/rxcq_ring_writer_bench.sv
module rxcq_ring_writer_bench;
  localparam int IDX_W = 16, LEN_W = 14, MAX_LOG2 = 4, CNT_W = 16;
  localparam int LOG_W = $clog2(MAX_LOG2 + 1), SLOT_W = MAX_LOG2, ENT_W = LEN_W + 3;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [LOG_W-1:0] cfg_ring_log2 = '0;
  logic dma_en = 1'b0, prod_wr = 1'b0, irq_mask = 1'b0, irq_clear = 1'b0;
  logic [IDX_W-1:0] prod_wdata = '0;
  logic pkt_valid = 1'b0, pkt_mac_err = 1'b0, pkt_trunc = 1'b0;
  logic [LEN_W-1:0] pkt_len = '0;
  logic cq_we, irq_pending, irq;
  logic [SLOT_W-1:0] cq_addr;
  logic [ENT_W-1:0] cq_wdata;
  logic [IDX_W-1:0] cons_idx;
  logic [CNT_W-1:0] drop_cnt;

  int n_chk = 0, n_bad = 0;
  int e_c = 0, e_p = 0, e_drop = 0, lg = 0;
  bit e_pend = 0, done = 0;

  always #10 clk = ~clk;

  rxcq_ring_writer u_rxcq_ring_writer (.*);

  task automatic chk(string req, string what, longint act, longint exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  task automatic check_state(string req);
    chk(req, "cons_idx", cons_idx, e_c);
    chk(req, "drop_cnt", drop_cnt, e_drop);
    chk(req, "irq_pending", irq_pending, e_pend);
    chk("R9", "irq", irq, e_pend & ~irq_mask);
  endtask

  task automatic do_reset(int new_lg);
    @(negedge clk);
    rst_n = 1'b0;
    cfg_ring_log2 = LOG_W'(new_lg);
    lg = new_lg; e_c = 0; e_p = 0; e_drop = 0; e_pend = 0;
    @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1", "cq_we", cq_we, 0);
    check_state("R1");
  endtask

  task automatic set_prod(int v);
    prod_wr = 1'b1; prod_wdata = IDX_W'(v);
    @(negedge clk);
    prod_wr = 1'b0;
    e_p = v;
  endtask

  task automatic send(int len, bit mac, bit tr, bit clr, string req);
    bit acc;
    pkt_valid = 1'b1; pkt_len = LEN_W'(len); pkt_mac_err = mac; pkt_trunc = tr;
    irq_clear = clr;
    acc = dma_en && (e_c != e_p);
    @(negedge clk);
    pkt_valid = 1'b0; irq_clear = 1'b0;
    if (acc) begin
      chk(req, "cq_we", cq_we, 1);
      chk("R2", "cq_addr", cq_addr, e_c % (1 << lg));
      chk("R3", "cq_wdata", cq_wdata,
          ((((e_c >> lg) & 1) << (LEN_W + 2)) | (tr << (LEN_W + 1)) | (mac << LEN_W) | len));
      chk("R4", "valid bit", cq_wdata[LEN_W+2], (e_c >> lg) & 1);
      e_c++;
      e_pend = 1;
    end else begin
      chk(req, "cq_we", cq_we, 0);
      if (dma_en) e_drop++;
      if (clr) e_pend = 0;
    end
    check_state(req);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_bad++; n_chk++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    do_reset(2);
    dma_en = 1'b1;
    send(60, 0, 0, 0, "R5");
    set_prod(4);
    for (int i = 0; i < 4; i++) send(100 + i, i[0], i[1], 0, "R3");
    send(77, 0, 0, 0, "R6");
    send(78, 1, 1, 0, "R6");
    irq_clear = 1'b1;
    @(negedge clk);
    irq_clear = 1'b0;
    e_pend = 0;
    check_state("R8");
    for (int r = 0; r < 4; r++) begin
      set_prod(e_p + 4);
      for (int i = 0; i < 4; i++) send((r * 997 + i * 131) % (1 << LEN_W), i[1], i[0], 0, "R4");
    end
    irq_mask = 1'b1;
    @(negedge clk);
    check_state("R9");
    set_prod(e_p + 2);
    send(5, 0, 0, 1, "R8");
    irq_mask = 1'b0;
    @(negedge clk);
    check_state("R9");
    dma_en = 1'b0;
    send(9, 1, 0, 0, "R7");
    set_prod(e_p);
    send(10, 0, 1, 0, "R7");
    dma_en = 1'b1;
    send(11, 0, 0, 0, "R2");

    do_reset(3);
    dma_en = 1'b1;
    set_prod(8);
    for (int i = 0; i < 10; i++) send(i * 3 + 1, 0, 0, 0, (i < 8) ? "R2" : "R6");
    set_prod(16);
    for (int i = 0; i < 8; i++) send(i + 200, i[2], 0, 0, "R4");

    do_reset(0);
    dma_en = 1'b1;
    for (int i = 0; i < 6; i++) begin
      set_prod(e_p + 1);
      send(i + 40, 0, 1, 0, "R4");
    end

    do_reset(MAX_LOG2);
    dma_en = 1'b1;
    set_prod(1 << MAX_LOG2);
    for (int i = 0; i < (1 << MAX_LOG2) + 1; i++) send(i, 1, 1, 0, "R2");

    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule